// File: doc/BRIEF.md
# Single-Accumulator Execution Core

This block is a small processor core built around one accumulator register. Each instruction carries an opcode and one address field, and the accumulator is always the hidden second operand and the destination. Instructions arrive on a valid/ready port and are not fetched by the core. The core reaches data through a synchronous memory port: read data arrives one cycle after the read strobe, and a write completes at the clock edge where the write strobe is high.

Arithmetic takes its explicit operand from memory. The address is either the address field alone or, in the indexed form, the address field plus an index register. A load-index instruction sets the index register. Instructions that read memory occupy the core for two cycles, and the instruction port is held off during the second cycle. All other instructions finish in one cycle. The accumulator is brought out as a port so that results can be observed.

Top module: `acc_core`

## Requirements
- R1: After synchronous reset the accumulator and the index register are zero and `in_ready` is high.
- R2: Opcode 0 (clear) sets the accumulator to zero at the accepting edge. It is a one-cycle instruction and drives no memory strobe.
- R3: Opcode 1 (add) raises `mem_rd` at address A in the accepting cycle and holds `in_ready` low for the following cycle. At the end of that cycle the accumulator becomes acc + mem[A] modulo 2^16.
- R4: Opcode 2 (subtract) behaves like add but produces acc − mem[A] modulo 2^16.
- R5: Opcode 3 (multiply) behaves like add but keeps the low 16 bits of acc × mem[A].
- R6: Opcode 4 (indexed add) reads address (A + index) modulo 2^ADDR_W and adds that word to the accumulator, with the timing of R3.
- R7: Opcode 5 (store) raises `mem_wr` for exactly the accepting cycle with `mem_addr` = A and `mem_wdata` = the current accumulator. It is a one-cycle instruction.
- R8: Opcode 6 (load index) copies the address field into the index register at the accepting edge. The next indexed add uses the new value.
- R9: Opcode 7 is a no-operation. It drives no memory strobe, and the accumulator and index register stay unchanged.
- R10: An instruction is taken only in a cycle where both `in_valid` and `in_ready` are high. In any other cycle no memory strobe is driven and no state changes, except the write-back of an instruction already in flight.
- R11: The nine-instruction sequence clear, add c, mul b, add a, store t, clear, add a, mul b, sub t, run with a=4, b=3 and c=2, leaves 2 in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The core can accept an instruction |
| in_op | input | 3 | Opcode |
| in_addr | input | ADDR_W | Address field |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| acc_out | output | 16 | Accumulator value |

## Verification
A memory write-back and the presentation of the next instruction can fall in the same cycle. The bench provokes this by keeping `in_valid` high with a store while an add is still in flight. It then checks three things: the store is refused while `in_ready` is low, the accumulator takes the sum in that cycle, and the store accepted on the following cycle writes the updated value. A second coincidence is a load-index directly followed by an indexed add. That case is judged by the address on `mem_addr` and by the sum that results.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DATA_W = 16;
    localparam int OP_W   = 3;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_CLR  = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MUL  = 3'd3,
        OP_ADDX = 3'd4,
        OP_ST   = 3'd5,
        OP_LDX  = 3'd6,
        OP_NOP  = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_MUL = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    rd;
        logic    wr;
        logic    clr;
        logic    ldx;
        logic    use_idx;
        alu_op_e alu;
    } ctl_t;

    function automatic word_t mul_low(word_t a, word_t b);
        logic [2*DATA_W-1:0] p;
        p = a * b;
        return p[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ctl_t            ctl
);
    always_comb begin
        ctl = '{rd: 1'b0, wr: 1'b0, clr: 1'b0, ldx: 1'b0,
                use_idx: 1'b0, alu: ALU_ADD};
        case (opcode_e'(op))
            OP_CLR:  ctl.clr = 1'b1;
            OP_ADD:  ctl.rd  = 1'b1;
            OP_SUB:  begin ctl.rd = 1'b1; ctl.alu = ALU_SUB; end
            OP_MUL:  begin ctl.rd = 1'b1; ctl.alu = ALU_MUL; end
            OP_ADDX: begin ctl.rd = 1'b1; ctl.use_idx = 1'b1; end
            OP_ST:   ctl.wr  = 1'b1;
            OP_LDX:  ctl.ldx = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_MUL: y = mul_low(a, b);
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_out
);
    ctl_t              ctl;
    word_t             acc_q;
    word_t             alu_y;
    logic [ADDR_W-1:0] idx_q;
    logic              busy_q;
    alu_op_e           pend_q;
    logic              take;

    acc_decode u_dec (.op(in_op), .ctl(ctl));
    acc_alu    u_alu (.op(pend_q), .a(acc_q), .b(mem_rdata), .y(alu_y));

    assign in_ready  = !busy_q;
    assign take      = in_valid && in_ready;
    assign mem_rd    = take && ctl.rd;
    assign mem_wr    = take && ctl.wr;
    assign mem_addr  = ctl.use_idx ? in_addr + idx_q : in_addr;
    assign mem_wdata = acc_q;
    assign acc_out   = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
            pend_q <= ALU_ADD;
        end else if (busy_q) begin
            acc_q  <= alu_y;
            busy_q <= 1'b0;
        end else if (take) begin
            if (ctl.clr) acc_q <= '0;
            if (ctl.ldx) idx_q <= in_addr;
            if (ctl.rd) begin
                busy_q <= 1'b1;
                pend_q <= ctl.alu;
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (acc_out == '0) && in_ready);

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (take && in_op == OP_CLR) |=> acc_out == '0);

    assert_read_stall_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !in_ready && !mem_rd && !mem_wr);

    assert_stall_ends_R3: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    assert_no_take_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && in_ready) |-> !mem_rd && !mem_wr);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && in_ready) |=> $stable(acc_out) && $stable(idx_q));

    assert_load_index_R8: assert property (@(posedge clk) disable iff (rst)
        (take && in_op == OP_LDX) |=> idx_q == $past(in_addr));

    assert_nop_R9: assert property (@(posedge clk) disable iff (rst)
        (take && in_op == OP_NOP) |=> $stable(acc_out) && $stable(idx_q) && in_ready);

    assert_store_data_R7: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_wdata == acc_out && in_ready);
endmodule

// File: tb/test_acc_core.sv
`timescale 1ns/1ps
module test_acc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = 3'd7;
    logic [7:0]  in_addr = '0;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata, acc_out;

    logic [15:0] mem [256];
    logic [15:0] model_acc = '0;
    logic [7:0]  model_idx = '0;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit compare_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_core #(.ADDR_W(8)) i_acc_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_out(acc_out));

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model: accumulator compared on every falling edge
    always @(negedge clk) begin
        if (compare_on)
            chk(acc_out === model_acc, "R10 per-cycle acc", acc_out, model_acc);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_op(input logic [2:0] op, input logic [7:0] a);
        logic [7:0]  ea;
        logic [15:0] m;
        bit rd;
        ea = (op == 3'd4) ? 8'(a + model_idx) : a;
        m  = mem[ea];
        rd = (op >= 3'd1 && op <= 3'd4);
        @(negedge clk);
        chk(in_ready === 1'b1, "R10 ready before issue", in_ready, 1);
        in_valid = 1'b1; in_op = op; in_addr = a;
        #1;
        chk(mem_rd === rd, "R10 read strobe", mem_rd, rd);
        chk(mem_wr === (op == 3'd5), "R7 write strobe", mem_wr, op == 3'd5);
        if (rd || op == 3'd5)
            chk(mem_addr === ea, "R6 effective address", mem_addr, ea);
        if (op == 3'd5)
            chk(mem_wdata === model_acc, "R7 write data", mem_wdata, model_acc);
        @(posedge clk);
        case (op)
            3'd0: model_acc = '0;
            3'd6: model_idx = a;
            default: ;
        endcase
        @(negedge clk);
        in_valid = 1'b0; in_op = 3'd7;
        if (rd) begin
            chk(in_ready === 1'b0, "R3 ready low in write-back", in_ready, 0);
            @(posedge clk);
            case (op)
                3'd2: model_acc = model_acc - m;
                3'd3: model_acc = 16'((32'(model_acc) * 32'(m)) & 32'hFFFF);
                default: model_acc = model_acc + m;
            endcase
            @(negedge clk);
        end
        if (op == 3'd5)
            chk(mem[a] === model_acc, "R7 stored word", mem[a], model_acc);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 1);
        mem[0] = 16'd4; mem[1] = 16'd3; mem[2] = 16'd2; mem[3] = 16'd0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(acc_out === 16'd0, "R1 acc after reset", acc_out, 0);
        chk(in_ready === 1'b1, "R1 ready after reset", in_ready, 1);
        compare_on = 1'b1;

        // R11 nine-instruction expression a*b-(a+c*b)
        do_op(3'd0, 8'd0); do_op(3'd1, 8'd2); do_op(3'd3, 8'd1);
        do_op(3'd1, 8'd0); do_op(3'd5, 8'd3); do_op(3'd0, 8'd0);
        do_op(3'd1, 8'd0); do_op(3'd3, 8'd1); do_op(3'd2, 8'd3);
        chk(acc_out === 16'd2, "R11 expression result", acc_out, 2);

        // R4 subtract wraps below zero
        do_op(3'd0, 8'd0);
        mem[20] = 16'd5;
        do_op(3'd2, 8'd20);
        chk(acc_out === 16'hFFFB, "R4 wrap", acc_out, 16'hFFFB);

        // R5 multiply keeps the low 16 bits
        do_op(3'd0, 8'd0);
        mem[21] = 16'd300;
        do_op(3'd1, 8'd21); do_op(3'd3, 8'd21);
        chk(acc_out === 16'd24464, "R5 low product", acc_out, 24464);

        // R8 then R6: load index, indexed add wraps the address
        do_op(3'd6, 8'h10);
        mem[5] = 16'd1000;
        do_op(3'd4, 8'hF5);
        chk(acc_out === 16'd25464, "R6 indexed add", acc_out, 25464);

        // R9 no-operation
        do_op(3'd7, 8'd9);
        do_op(3'd4, 8'hF5);
        chk(acc_out === 16'd26464, "R9 index kept after nop", acc_out, 26464);

        // R10 valid low: nothing taken
        @(negedge clk);
        in_op = 3'd0; in_addr = 8'd0;
        #1;
        chk(mem_rd === 1'b0, "R10 no strobe when idle", mem_rd, 0);
        @(negedge clk);
        chk(acc_out === model_acc, "R10 acc kept when idle", acc_out, model_acc);
        in_op = 3'd7;

        // R3 with R7: store held while add writes back
        do_op(3'd0, 8'd0);
        mem[30] = 16'd77;
        mem[31] = 16'd0;
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'd1; in_addr = 8'd30;
        @(posedge clk);
        @(negedge clk);
        in_op = 3'd5; in_addr = 8'd31;
        #1;
        chk(in_ready === 1'b0, "R3 stall ready", in_ready, 0);
        chk(mem_wr === 1'b0, "R10 store refused in stall", mem_wr, 0);
        @(posedge clk);
        model_acc = 16'd77;
        @(negedge clk);
        chk(in_ready === 1'b1, "R3 ready after write-back", in_ready, 1);
        chk(mem_wr === 1'b1 && mem_wdata === 16'd77, "R7 store sees fresh acc",
            mem_wdata, 77);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_op = 3'd7;
        chk(mem[31] === 16'd77, "R7 stored fresh acc", mem[31], 77);

        // R2 clear is one cycle
        do_op(3'd0, 8'd0);
        chk(acc_out === 16'd0 && in_ready === 1'b1, "R2 clear", acc_out, 0);

        // R1 reset clears index too
        @(negedge clk); rst = 1'b1; compare_on = 1'b0;
        @(negedge clk); rst = 1'b0; model_acc = '0; model_idx = '0;
        compare_on = 1'b1;
        mem[8] = 16'd11;
        do_op(3'd4, 8'd8);
        chk(acc_out === 16'd11, "R1 index zero after reset", acc_out, 11);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule